// File: doc/BRIEF.md
# Command Queue Doorbell and Completion Tracker

This block is the task bookkeeping core of a command queue engine. Software queues tasks by ringing per-slot doorbell bits over a 32-bit register port. A stub execution engine reports each finished or failed task by its tag. The block keeps the pending and finished bitmaps. It latches interrupt causes into a status register that software clears by writing ones, and it drives a single interrupt line. A halt handshake waits until no transfer is in flight. A clear-all-tasks operation, which is only allowed while halted, empties the queue in one step.

A configuration register holds a master enable and two fields: the direct-command reservation and the descriptor width. Software may change the two fields only while the enable is clear. When direct commands are reserved, the top slot is set aside and the reported queue depth drops by one. Clearing the enable wipes all task state but keeps the configuration fields. Register reads are combinational from the current address. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `cmdq_doorbell_ctrl`

## Requirements
- R1: After reset every register reads 0, except the depth register (word 8), which reads 32. `irq` is low.
- R2: Writing word 5 (doorbell) sets each slot bit written as 1 and leaves the other bits unchanged. A pending bit reads back as 1. Doorbell writes have no effect while the enable (word 0 bit 0) is clear.
- R3: An engine report without error for a pending tag clears that doorbell bit and sets the same bit in word 6 (completion). It also raises the task-complete cause (status bit 0). A report for a tag that is not pending changes nothing. Writing ones to word 6 clears those completion bits.
- R4: The status register (word 2) has four causes: bit 0 task complete, bit 1 task error, bit 2 tasks cleared and bit 3 halt done. It is cleared by writing ones. A cause is latched only when its bit in word 3 (status enable) is 1. `irq` is high exactly when a status bit and its bit in word 4 (signal enable) are both 1.
- R5: An engine error report for a pending tag leaves the doorbell bit set and raises cause bit 1. It records the tag in word 7. A command error sets bit 15 and writes the tag to bits [4:0]. A data error sets bit 31 and writes the tag to bits [20:16]. While a section is valid, later errors do not overwrite it. Writing 1 to a valid bit clears that valid bit.
- R6: Writing word 1 with bit 0 set requests a halt. Word 1 bit 0 reads 1 after the engine has been idle (`eng_busy` low) for HALT_LAT consecutive cycles (default 4), and cause bit 3 is raised at that moment. A busy cycle restarts the count. Writing word 1 with bit 0 clear resumes operation.
- R7: Writing word 1 with bits 1 and 0 set while halted makes bit 1 read 1 for one cycle. After that cycle bit 1 clears, every doorbell bit is discarded and cause bit 2 is raised. The same request made while not halted is ignored.
- R8: Word 0 bit 1 (direct-command reservation) and bit 2 (wide descriptor) change on a write only if the enable was clear before that write. Bit 0 (the enable) is always writable.
- R9: Word 8 reads 32 when the direct-command reservation is clear and 31 when it is set.
- R10: While the enable is clear, the doorbell, completion, error info and halt state read 0, and the configuration fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| eng_vld | input | 1 | Engine reports an outcome this cycle |
| eng_tag | input | 5 | Tag of the reported task |
| eng_err | input | 1 | Report is an error, not a completion |
| eng_err_data | input | 1 | Error is in the data phase (else command phase) |
| eng_busy | input | 1 | Engine is transferring; delays halt |
| irq | output | 1 | Interrupt request |

## Verification
A table of vectors first rings doorbells on scattered slots (0, 5, 31). It then finishes tasks out of order, so that it can tell whether completion clears only the reported bit and whether write-one-to-clear clears only the written bits. Error reports of both kinds, followed by a second error, show whether each section is latched separately and whether the first error is held. Directed sequences separate the status-enable gate from the signal-enable gate and report a tag that is not pending. They time the halt against a busy engine down to the exact cycle. They issue clear-all both while halted and while running, and they check that disabling wipes task state while the configuration is kept.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_CFG   = 4'd0;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 4'd1;
  localparam logic [REG_AW-1:0] OFS_ISTAT = 4'd2;
  localparam logic [REG_AW-1:0] OFS_ISTEN = 4'd3;
  localparam logic [REG_AW-1:0] OFS_ISIG  = 4'd4;
  localparam logic [REG_AW-1:0] OFS_DB    = 4'd5;
  localparam logic [REG_AW-1:0] OFS_COMPL = 4'd6;
  localparam logic [REG_AW-1:0] OFS_ERR   = 4'd7;
  localparam logic [REG_AW-1:0] OFS_DEPTH = 4'd8;

  localparam int NUM_CAUSE = 4;
  localparam int CAUSE_TC  = 0;
  localparam int CAUSE_RED = 1;
  localparam int CAUSE_TCL = 2;
  localparam int CAUSE_HAC = 3;

  localparam int ERR_CMD_VLD_BIT = 15;
  localparam int ERR_DAT_TAG_LSB = 16;
  localparam int ERR_DAT_VLD_BIT = 31;
endpackage

// File: rtl/cmdq_slot_track.sv
module cmdq_slot_track #(
  parameter int NUM_SLOTS = 32,
  localparam int TAG_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wipe,
  input  logic                 clear_all,
  input  logic [NUM_SLOTS-1:0] db_set,
  input  logic [NUM_SLOTS-1:0] compl_clr,
  input  logic                 err_clr_cmd,
  input  logic                 err_clr_dat,
  input  logic                 eng_vld,
  input  logic [TAG_W-1:0]     eng_tag,
  input  logic                 eng_err,
  input  logic                 eng_err_data,
  output logic [NUM_SLOTS-1:0] db_q,
  output logic [NUM_SLOTS-1:0] compl_q,
  output logic                 cmd_vld_q,
  output logic [TAG_W-1:0]     cmd_tag_q,
  output logic                 dat_vld_q,
  output logic [TAG_W-1:0]     dat_tag_q,
  output logic                 tc_evt,
  output logic                 red_evt
);
  logic [NUM_SLOTS-1:0] db_d, compl_d, tag_mask, done_mask;
  logic                 cmd_vld_d, dat_vld_d, hit;
  logic [TAG_W-1:0]     cmd_tag_d, dat_tag_d;

  always_comb begin
    tag_mask  = {{(NUM_SLOTS-1){1'b0}}, 1'b1} << eng_tag;
    hit       = eng_vld && db_q[eng_tag];
    done_mask = (hit && !eng_err) ? tag_mask : '0;
    tc_evt    = |done_mask;
    red_evt   = hit && eng_err;
    cmd_vld_d = cmd_vld_q;
    cmd_tag_d = cmd_tag_q;
    dat_vld_d = dat_vld_q;
    dat_tag_d = dat_tag_q;
    if (err_clr_cmd) cmd_vld_d = 1'b0;
    if (err_clr_dat) dat_vld_d = 1'b0;
    if (red_evt && !eng_err_data && !cmd_vld_q) begin
      cmd_vld_d = 1'b1;
      cmd_tag_d = eng_tag;
    end
    if (red_evt && eng_err_data && !dat_vld_q) begin
      dat_vld_d = 1'b1;
      dat_tag_d = eng_tag;
    end
    db_d    = (clear_all) ? '0 : ((db_q | db_set) & ~done_mask);
    compl_d = (compl_q & ~compl_clr) | done_mask;
    if (wipe) begin
      db_d      = '0;
      compl_d   = '0;
      cmd_vld_d = 1'b0;
      cmd_tag_d = '0;
      dat_vld_d = 1'b0;
      dat_tag_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q      <= '0;
      compl_q   <= '0;
      cmd_vld_q <= 1'b0;
      cmd_tag_q <= '0;
      dat_vld_q <= 1'b0;
      dat_tag_q <= '0;
    end else begin
      db_q      <= db_d;
      compl_q   <= compl_d;
      cmd_vld_q <= cmd_vld_d;
      cmd_tag_q <= cmd_tag_d;
      dat_vld_q <= dat_vld_d;
      dat_tag_q <= dat_tag_d;
    end
  end
endmodule

// File: rtl/cmdq_halt_ctl.sv
module cmdq_halt_ctl #(
  parameter int HALT_LAT = 4,
  localparam int CNT_W = (HALT_LAT > 1) ? $clog2(HALT_LAT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe,
  input  logic ctrl_wr,
  input  logic halt_bit,
  input  logic clr_bit,
  input  logic eng_busy,
  output logic halt_req_q,
  output logic halted_q,
  output logic clr_pend_q,
  output logic clear_fire,
  output logic hac_evt
);
  logic             req_d, halted_d, clr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    req_d      = halt_req_q;
    halted_d   = halted_q;
    clr_d      = clr_pend_q;
    cnt_d      = cnt_q;
    hac_evt    = 1'b0;
    clear_fire = 1'b0;
    if (clr_pend_q) begin
      clr_d      = 1'b0;
      clear_fire = 1'b1;
    end
    if (halt_req_q && !halted_q) begin
      if (eng_busy) begin
        cnt_d = '0;
      end else if (cnt_q == CNT_W'(HALT_LAT - 1)) begin
        halted_d = 1'b1;
        cnt_d    = '0;
        hac_evt  = 1'b1;
      end else begin
        cnt_d = CNT_W'(cnt_q + 1'b1);
      end
    end
    if (ctrl_wr) begin
      req_d = halt_bit;
      if (!halt_bit) begin
        halted_d = 1'b0;
        cnt_d    = '0;
        hac_evt  = 1'b0;
      end
      if (halt_bit && clr_bit && halted_q) clr_d = 1'b1;
    end
    if (wipe) begin
      req_d      = 1'b0;
      halted_d   = 1'b0;
      clr_d      = 1'b0;
      cnt_d      = '0;
      hac_evt    = 1'b0;
      clear_fire = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req_q <= 1'b0;
      halted_q   <= 1'b0;
      clr_pend_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      halt_req_q <= req_d;
      halted_q   <= halted_d;
      clr_pend_q <= clr_d;
      cnt_q      <= cnt_d;
    end
  end
endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq #(
  parameter int NC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] cause_evt,
  input  logic          stat_wr,
  input  logic          en_wr,
  input  logic          sig_wr,
  input  logic [NC-1:0] wdata,
  output logic [NC-1:0] istat_q,
  output logic [NC-1:0] isten_q,
  output logic [NC-1:0] isig_q,
  output logic          irq
);
  logic [NC-1:0] istat_d, w1c;

  always_comb begin
    w1c     = stat_wr ? wdata : '0;
    istat_d = (istat_q & ~w1c) | (cause_evt & isten_q);
    irq     = |(istat_q & isig_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istat_q <= '0;
      isten_q <= '0;
      isig_q  <= '0;
    end else begin
      istat_q <= istat_d;
      if (en_wr)  isten_q <= wdata;
      if (sig_wr) isig_q  <= wdata;
    end
  end
endmodule

// File: rtl/cmdq_doorbell_ctrl.sv
module cmdq_doorbell_ctrl
  import cmdq_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int HALT_LAT  = 4,
  localparam int TAG_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              eng_vld,
  input  logic [TAG_W-1:0]  eng_tag,
  input  logic              eng_err,
  input  logic              eng_err_data,
  input  logic              eng_busy,
  output logic              irq
);
  logic cfg_en_q, cfg_dcmd_q, cfg_wide_q;
  logic cfg_en_d, cfg_dcmd_d, cfg_wide_d;
  logic wr_cfg, wr_ctrl, wr_stat, wr_sten, wr_sig, wr_db, wr_compl, wr_err;
  logic wipe;
  logic [NUM_SLOTS-1:0] db_q, compl_q;
  logic cmd_vld_q, dat_vld_q;
  logic [TAG_W-1:0] cmd_tag_q, dat_tag_q;
  logic tc_evt, red_evt, hac_evt, clear_fire;
  logic halt_req_q, halted_q, clr_pend_q;
  logic [NUM_CAUSE-1:0] cause_evt, istat_q, isten_q, isig_q;

  always_comb begin
    wr_cfg   = reg_wr && (reg_addr == OFS_CFG);
    wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
    wr_stat  = reg_wr && (reg_addr == OFS_ISTAT);
    wr_sten  = reg_wr && (reg_addr == OFS_ISTEN);
    wr_sig   = reg_wr && (reg_addr == OFS_ISIG);
    wr_db    = reg_wr && (reg_addr == OFS_DB) && cfg_en_q;
    wr_compl = reg_wr && (reg_addr == OFS_COMPL);
    wr_err   = reg_wr && (reg_addr == OFS_ERR);
    cfg_en_d   = wr_cfg ? reg_wdata[0] : cfg_en_q;
    cfg_dcmd_d = (wr_cfg && !cfg_en_q) ? reg_wdata[1] : cfg_dcmd_q;
    cfg_wide_d = (wr_cfg && !cfg_en_q) ? reg_wdata[2] : cfg_wide_q;
    wipe       = !cfg_en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q   <= 1'b0;
      cfg_dcmd_q <= 1'b0;
      cfg_wide_q <= 1'b0;
    end else begin
      cfg_en_q   <= cfg_en_d;
      cfg_dcmd_q <= cfg_dcmd_d;
      cfg_wide_q <= cfg_wide_d;
    end
  end

  cmdq_slot_track #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .wipe         (wipe),
    .clear_all    (clear_fire),
    .db_set       (wr_db ? reg_wdata[NUM_SLOTS-1:0] : '0),
    .compl_clr    (wr_compl ? reg_wdata[NUM_SLOTS-1:0] : '0),
    .err_clr_cmd  (wr_err && reg_wdata[ERR_CMD_VLD_BIT]),
    .err_clr_dat  (wr_err && reg_wdata[ERR_DAT_VLD_BIT]),
    .eng_vld      (eng_vld),
    .eng_tag      (eng_tag),
    .eng_err      (eng_err),
    .eng_err_data (eng_err_data),
    .db_q         (db_q),
    .compl_q      (compl_q),
    .cmd_vld_q    (cmd_vld_q),
    .cmd_tag_q    (cmd_tag_q),
    .dat_vld_q    (dat_vld_q),
    .dat_tag_q    (dat_tag_q),
    .tc_evt       (tc_evt),
    .red_evt      (red_evt)
  );

  cmdq_halt_ctl #(.HALT_LAT(HALT_LAT)) u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wipe       (wipe),
    .ctrl_wr    (wr_ctrl),
    .halt_bit   (reg_wdata[0]),
    .clr_bit    (reg_wdata[1]),
    .eng_busy   (eng_busy),
    .halt_req_q (halt_req_q),
    .halted_q   (halted_q),
    .clr_pend_q (clr_pend_q),
    .clear_fire (clear_fire),
    .hac_evt    (hac_evt)
  );

  always_comb begin
    cause_evt            = '0;
    cause_evt[CAUSE_TC]  = tc_evt;
    cause_evt[CAUSE_RED] = red_evt;
    cause_evt[CAUSE_TCL] = clear_fire;
    cause_evt[CAUSE_HAC] = hac_evt;
  end

  cmdq_irq #(.NC(NUM_CAUSE)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cause_evt (cause_evt),
    .stat_wr   (wr_stat),
    .en_wr     (wr_sten),
    .sig_wr    (wr_sig),
    .wdata     (reg_wdata[NUM_CAUSE-1:0]),
    .istat_q   (istat_q),
    .isten_q   (isten_q),
    .isig_q    (isig_q),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CFG:   reg_rdata[2:0] = {cfg_wide_q, cfg_dcmd_q, cfg_en_q};
      OFS_CTRL:  reg_rdata[1:0] = {clr_pend_q, halted_q};
      OFS_ISTAT: reg_rdata[NUM_CAUSE-1:0] = istat_q;
      OFS_ISTEN: reg_rdata[NUM_CAUSE-1:0] = isten_q;
      OFS_ISIG:  reg_rdata[NUM_CAUSE-1:0] = isig_q;
      OFS_DB:    reg_rdata[NUM_SLOTS-1:0] = db_q;
      OFS_COMPL: reg_rdata[NUM_SLOTS-1:0] = compl_q;
      OFS_ERR: begin
        reg_rdata[TAG_W-1:0]             = cmd_tag_q;
        reg_rdata[ERR_CMD_VLD_BIT]       = cmd_vld_q;
        reg_rdata[ERR_DAT_TAG_LSB+:TAG_W] = dat_tag_q;
        reg_rdata[ERR_DAT_VLD_BIT]       = dat_vld_q;
      end
      OFS_DEPTH: reg_rdata = REG_DW'(NUM_SLOTS) - REG_DW'(cfg_dcmd_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmdq_doorbell_ctrl_chk.sv
module cmdq_doorbell_ctrl_chk #(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [NUM_SLOTS-1:0] db,
  input logic [NUM_SLOTS-1:0] compl,
  input logic                 halt_req,
  input logic                 halted,
  input logic                 clr_pend
);
  // R10: disabled engine holds no task or halt state
  a_r10_wiped_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (db == '0 && compl == '0 && !halted));

  // R7: clear-all is only pending while halted
  a_r7_clear_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |-> halted);

  // R7: clear-all finishes after one cycle
  a_r7_clear_self_ends: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> !clr_pend);

  // R6: halted only follows an outstanding request
  a_r6_halt_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(halt_req));

  // R3: a completion bit only appears for a slot that was pending
  a_r3_compl_from_db: assert property (@(posedge clk) disable iff (!rst_n)
    (compl & ~$past(compl) & ~$past(db)) == '0);
endmodule

bind cmdq_doorbell_ctrl cmdq_doorbell_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (cfg_en_q),
  .db       (db_q),
  .compl    (compl_q),
  .halt_req (halt_req_q),
  .halted   (halted_q),
  .clr_pend (clr_pend_q)
);

// File: tb/cmdq_doorbell_ctrl_tb.sv
module cmdq_doorbell_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALT_LAT   = 4;
  localparam int NVEC       = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_vld = 1'b0;
  logic [4:0]  eng_tag = '0;
  logic        eng_err = 1'b0;
  logic        eng_err_data = 1'b0;
  logic        eng_busy = 1'b0;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  logic        finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_doorbell_ctrl #(.NUM_SLOTS(32), .HALT_LAT(HALT_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_vld(eng_vld),
    .eng_tag(eng_tag), .eng_err(eng_err), .eng_err_data(eng_err_data),
    .eng_busy(eng_busy), .irq(irq)
  );

  // {op, addr, data, expected}; op 0 write, 1 read-check, 2 finish tag, 3 error (data[8]=data phase)
  localparam logic [71:0] VEC [NVEC] = '{
    {4'd0, 4'd0, 32'h1,        32'h0},        // enable
    {4'd0, 4'd3, 32'hF,        32'h0},        // status enable
    {4'd0, 4'd4, 32'hF,        32'h0},        // signal enable
    {4'd0, 4'd5, 32'h1,        32'h0},        // R2 ring slot 0
    {4'd0, 4'd5, 32'h20,       32'h0},        // R2 ring slot 5
    {4'd1, 4'd5, 32'h0,        32'h21},       // R2 both pending
    {4'd2, 4'd0, 32'd5,        32'h0},        // R3 finish slot 5
    {4'd1, 4'd5, 32'h0,        32'h1},        // R3 doorbell bit gone
    {4'd1, 4'd6, 32'h0,        32'h20},       // R3 completion bit set
    {4'd1, 4'd2, 32'h0,        32'h1},        // R4 task complete cause
    {4'd0, 4'd6, 32'h20,       32'h0},        // R3 clear completion
    {4'd1, 4'd6, 32'h0,        32'h0},        // R3
    {4'd0, 4'd2, 32'h1,        32'h0},        // R4 clear status
    {4'd1, 4'd2, 32'h0,        32'h0},        // R4
    {4'd3, 4'd0, 32'h000,      32'h0},        // R5 command error slot 0
    {4'd1, 4'd7, 32'h0,        32'h00008000}, // R5
    {4'd1, 4'd2, 32'h0,        32'h2},        // R5 error cause
    {4'd3, 4'd0, 32'h100,      32'h0},        // R5 data error slot 0
    {4'd0, 4'd5, 32'h80000000, 32'h0},        // R2 ring slot 31
    {4'd3, 4'd0, 32'h01F,      32'h0},        // R5 second command error ignored
    {4'd1, 4'd7, 32'h0,        32'h80008000}, // R5 first error held
    {4'd0, 4'd7, 32'h80008000, 32'h0},        // R5 clear valids
    {4'd1, 4'd7, 32'h0,        32'h0}         // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic eng(input logic [4:0] t, input logic e, input logic dp);
    @(negedge clk);
    eng_vld = 1'b1; eng_tag = t; eng_err = e; eng_err_data = dp;
    @(posedge clk); #1;
    eng_vld = 1'b0; eng_err = 1'b0; eng_err_data = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", 4'(a), 32'h0);
    rd("R1 depth", 4'd8, 32'd32);
    check("R1 irq", {31'd0, irq}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][71:68])
        4'd0: wr(VEC[i][67:64], VEC[i][63:32]);
        4'd1: rd($sformatf("table row %0d", i), VEC[i][67:64], VEC[i][31:0]);
        4'd2: eng(VEC[i][36:32], 1'b0, 1'b0);
        default: eng(VEC[i][36:32], 1'b1, VEC[i][40]);
      endcase
    end
    rd("R2 slot 31 and slot 0 pending", 4'd5, 32'h80000001);

    // R4 gating of status and signal
    wr(4'd2, 32'hF);
    wr(4'd4, 32'h0);
    eng(5'd0, 1'b0, 1'b0);
    rd("R4 cause latched", 4'd2, 32'h1);
    check("R4 irq masked", {31'd0, irq}, 32'h0);
    wr(4'd4, 32'hF);
    @(negedge clk);
    check("R4 irq raised", {31'd0, irq}, 32'h1);
    wr(4'd2, 32'h1);
    @(negedge clk);
    check("R4 irq cleared", {31'd0, irq}, 32'h0);
    wr(4'd3, 32'hE);
    wr(4'd5, 32'h2);
    eng(5'd1, 1'b0, 1'b0);
    rd("R4 disabled cause not latched", 4'd2, 32'h0);
    eng(5'd2, 1'b0, 1'b0);
    rd("R3 non-pending tag ignored", 4'd6, 32'h3);
    wr(4'd3, 32'hF);
    wr(4'd6, 32'h3);

    // R6 halt handshake
    @(negedge clk); eng_busy = 1'b1;
    wr(4'd1, 32'h1);
    repeat (8) @(posedge clk);
    rd("R6 busy blocks halt", 4'd1, 32'h0);
    @(negedge clk); eng_busy = 1'b0;
    repeat (HALT_LAT-1) @(posedge clk);
    rd("R6 not yet halted", 4'd1, 32'h0);
    @(posedge clk);
    rd("R6 halted", 4'd1, 32'h1);
    rd("R6 halt cause", 4'd2, 32'h8);

    // R7 clear-all while halted
    wr(4'd5, 32'h4);
    wr(4'd1, 32'h3);
    rd("R7 clear pending", 4'd1, 32'h3);
    rd("R7 clear done", 4'd1, 32'h1);
    rd("R7 queue emptied", 4'd5, 32'h0);
    rd("R7 cleared cause", 4'd2, 32'hC);
    wr(4'd1, 32'h0);
    rd("R6 resumed", 4'd1, 32'h0);
    wr(4'd5, 32'h8);
    wr(4'd1, 32'h2);
    rd("R7 ignored when running", 4'd1, 32'h0);
    rd("R7 queue kept", 4'd5, 32'h8);

    // R10 disable wipes task state
    eng(5'd3, 1'b0, 1'b0);
    rd("R3 finish slot 3", 4'd6, 32'h8);
    wr(4'd5, 32'h10);
    eng(5'd4, 1'b1, 1'b0);
    rd("R5 command error tag 4", 4'd7, 32'h00008004);
    wr(4'd1, 32'h1);
    repeat (HALT_LAT+2) @(posedge clk);
    rd("R6 halted again", 4'd1, 32'h1);
    wr(4'd0, 32'h0);
    rd("R10 cfg", 4'd0, 32'h0);
    rd("R10 doorbell", 4'd5, 32'h0);
    rd("R10 completion", 4'd6, 32'h0);
    rd("R10 error info", 4'd7, 32'h0);
    rd("R10 halt", 4'd1, 32'h0);
    wr(4'd5, 32'h1);
    rd("R2 doorbell ignored when disabled", 4'd5, 32'h0);

    // R8 / R9 configuration lock and depth
    wr(4'd0, 32'h6);
    rd("R8 fields written while disabled", 4'd0, 32'h6);
    rd("R9 depth with reservation", 4'd8, 32'd31);
    wr(4'd0, 32'h7);
    rd("R8 enable set", 4'd0, 32'h7);
    wr(4'd0, 32'h1);
    rd("R8 fields locked while enabled", 4'd0, 32'h7);
    wr(4'd0, 32'h0);
    rd("R10 config kept after disable", 4'd0, 32'h6);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule